// File: doc/BRIEF.md
# Multiplierless Three-Tap Shift-Add FIR Filter

This block is a second-order FIR filter whose three coefficients are all powers of two, so no multiplier is built. Every tap product is an arithmetic right shift of a sign-extended sample. A negative tap is applied by inverting the shifted value and adding one. The block takes one signed 16-bit sample per clock, qualified by a valid strobe, and gives one filtered sample per accepted input.

The parameter `TAP_SET` selects one of two coefficient sets. `TAPS_SMOOTH` is a low-pass set with weights +1/4, +1/2, +1/4. `TAPS_EDGE` is a high-pass set with weights +1/4, -1/2, +1/4. The parameter `FORM` selects one of two structures. `FORM_DIRECT` keeps a two-deep sample delay line and adds all three products in one cycle, which puts two adders in series. `FORM_RETIMED` is the transposed form: it keeps registered partial sums, so only one adder sits before the output register. The two structures give bit-identical outputs with the same one-cycle latency.

The datapath is two guard bits wider than the sample. The output is the low 16 bits of the internal sum.

Top module: `shfir_top`

## Requirements
- R1: A synchronous active-high reset clears the output sample to 0, out_valid to 0 and all history. The first output after reset therefore depends only on the new sample.
- R2: With TAPS_SMOOTH, each output equals (x[n]>>>2) + (x[n-1]>>>1) + (x[n-2]>>>2). Here >>> is an arithmetic shift that rounds toward minus infinity, and x[n-k] is the k-th earlier accepted sample.
- R3: With TAPS_EDGE, the middle term is subtracted: y = (x[n]>>>2) - (x[n-1]>>>1) + (x[n-2]>>>2).
- R4: A sample accepted with in_valid high at a rising edge produces its output at that same edge. out_valid is high in the following cycle exactly when in_valid was high at that edge.
- R5: While in_valid is low, the history is not advanced and out_sample keeps its value. A gap inserts no zero samples.
- R6: FORM_DIRECT and FORM_RETIMED give bit-identical out_sample and out_valid for every input sequence.
- R7: Full-scale inputs give exact in-range results. With TAPS_SMOOTH, three samples of 32767 give 32765. With TAPS_EDGE, the sequence -32768, 32767, -32768 gives -32767.
- R8: Negative samples use arithmetic shifts. For example, -1 contributes -1 through a quarter tap and -1 through a half tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies in_sample for the current cycle |
| in_sample | input | 16 | Signed two's-complement input sample |
| out_valid | output | 1 | High for one cycle per accepted sample |
| out_sample | output | 16 | Signed filtered output, held between valid outputs |

## Verification
The assertions assume that in_valid and in_sample are stable around each rising edge. They also assume that reset is held for at least one edge before the first sample. They place no limit on the sample values, so the reference in the checker has to cover the full signed range, including -32768. The bench changes its inputs only on falling edges and holds reset for several cycles. It covers gaps, negative values, the most negative and most positive codes, and a reset in the middle of a stream, all within those assumptions.

// File: rtl/shfir_pkg.sv
package shfir_pkg;

    // Coefficient set selector
    typedef enum logic {
        TAPS_SMOOTH = 1'b0,   // +1/4, +1/2, +1/4
        TAPS_EDGE   = 1'b1    // +1/4, -1/2, +1/4
    } tap_set_e;

    // Structure selector
    typedef enum logic {
        FORM_DIRECT  = 1'b0,  // delay line, two adders in series
        FORM_RETIMED = 1'b1   // registered partial sums, one adder
    } form_e;

    localparam int TAP_COUNT = 3;

    // Descriptor of one power-of-two tap
    typedef struct packed {
        logic [3:0] shift;
        logic       negate;
    } tap_coef_t;

    function automatic tap_coef_t tap_coef(tap_set_e set, int idx);
        tap_coef_t c;
        c.shift  = (idx == 1) ? 4'd1 : 4'd2;
        c.negate = (set == TAPS_EDGE) && (idx == 1);
        return c;
    endfunction

    function automatic int tap_shift(tap_set_e set, int idx);
        tap_coef_t c;
        c = tap_coef(set, idx);
        return int'(c.shift);
    endfunction

    function automatic bit tap_negated(tap_set_e set, int idx);
        tap_coef_t c;
        c = tap_coef(set, idx);
        return c.negate;
    endfunction

endpackage

// File: rtl/shfir_term.sv
module shfir_term #(
    parameter int DATA_W  = 16,
    parameter int GUARD_W = 2,
    parameter int SHIFT   = 2,
    parameter bit NEGATE  = 1'b0
) (
    input  logic signed [DATA_W-1:0]         x,
    output logic signed [DATA_W+GUARD_W-1:0] p
);
    localparam int ACC_W = DATA_W + GUARD_W;
    localparam logic [ACC_W-1:0] ONE = {{(ACC_W-1){1'b0}}, 1'b1};

    logic signed [ACC_W-1:0] wide;
    logic signed [ACC_W-1:0] shifted;

    // sign extension into the guard bits, then an arithmetic shift
    assign wide    = {{GUARD_W{x[DATA_W-1]}}, x};
    assign shifted = wide >>> SHIFT;

    generate
        if (NEGATE) begin : g_neg
            // two's-complement negation: invert, then add one
            assign p = (~shifted) + ONE;
        end else begin : g_pos
            assign p = shifted;
        end
    endgenerate
endmodule

// File: rtl/shfir_direct.sv
module shfir_direct
    import shfir_pkg::*;
#(
    parameter int       DATA_W  = 16,
    parameter int       GUARD_W = 2,
    parameter tap_set_e TAP_SET = TAPS_SMOOTH
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    output logic signed [DATA_W-1:0] out_sample
);
    localparam int ACC_W = DATA_W + GUARD_W;

    logic signed [DATA_W-1:0] dly    [1:TAP_COUNT-1];
    logic signed [DATA_W-1:0] tap_in [TAP_COUNT];
    logic signed [ACC_W-1:0]  prod   [TAP_COUNT];
    logic signed [ACC_W-1:0]  acc;

    always_comb begin
        tap_in[0] = in_sample;
        for (int k = 1; k < TAP_COUNT; k++) tap_in[k] = dly[k];
    end

    generate
        for (genvar k = 0; k < TAP_COUNT; k++) begin : g_tap
            shfir_term #(
                .DATA_W (DATA_W),
                .GUARD_W(GUARD_W),
                .SHIFT  (tap_shift(TAP_SET, k)),
                .NEGATE (tap_negated(TAP_SET, k))
            ) u_term (
                .x(tap_in[k]),
                .p(prod[k])
            );
        end
    endgenerate

    // all products summed in one cycle: adders in series
    always_comb begin
        acc = '0;
        for (int k = 0; k < TAP_COUNT; k++) acc = acc + prod[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 1; k < TAP_COUNT; k++) dly[k] <= '0;
            out_sample <= '0;
        end else if (in_valid) begin
            dly[1] <= in_sample;
            for (int k = 2; k < TAP_COUNT; k++) dly[k] <= dly[k-1];
            out_sample <= acc[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/shfir_retimed.sv
module shfir_retimed
    import shfir_pkg::*;
#(
    parameter int       DATA_W  = 16,
    parameter int       GUARD_W = 2,
    parameter tap_set_e TAP_SET = TAPS_SMOOTH
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    output logic signed [DATA_W-1:0] out_sample
);
    localparam int ACC_W = DATA_W + GUARD_W;

    logic signed [ACC_W-1:0] prod [TAP_COUNT];
    logic signed [ACC_W-1:0] part [1:TAP_COUNT-1];
    logic signed [ACC_W-1:0] head;

    generate
        for (genvar k = 0; k < TAP_COUNT; k++) begin : g_tap
            shfir_term #(
                .DATA_W (DATA_W),
                .GUARD_W(GUARD_W),
                .SHIFT  (tap_shift(TAP_SET, k)),
                .NEGATE (tap_negated(TAP_SET, k))
            ) u_term (
                .x(in_sample),
                .p(prod[k])
            );
        end
    endgenerate

    // one adder before the output register
    assign head = prod[0] + part[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 1; k < TAP_COUNT; k++) part[k] <= '0;
            out_sample <= '0;
        end else if (in_valid) begin
            part[TAP_COUNT-1] <= prod[TAP_COUNT-1];
            for (int k = 1; k < TAP_COUNT-1; k++) part[k] <= prod[k] + part[k+1];
            out_sample <= head[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/shfir_top.sv
module shfir_top
    import shfir_pkg::*;
#(
    parameter int       DATA_W  = 16,
    parameter int       GUARD_W = 2,
    parameter tap_set_e TAP_SET = TAPS_SMOOTH,
    parameter form_e    FORM    = FORM_DIRECT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sample
);
    logic signed [DATA_W-1:0] core_out;

    generate
        if (FORM == FORM_DIRECT) begin : g_direct
            shfir_direct #(
                .DATA_W(DATA_W), .GUARD_W(GUARD_W), .TAP_SET(TAP_SET)
            ) u_core (
                .clk(clk), .rst(rst), .in_valid(in_valid),
                .in_sample(in_sample), .out_sample(core_out)
            );
        end else begin : g_retimed
            shfir_retimed #(
                .DATA_W(DATA_W), .GUARD_W(GUARD_W), .TAP_SET(TAP_SET)
            ) u_core (
                .clk(clk), .rst(rst), .in_valid(in_valid),
                .in_sample(in_sample), .out_sample(core_out)
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
    end

    assign out_sample = core_out;
endmodule

// File: rtl/shfir_checker.sv
module shfir_checker
    import shfir_pkg::*;
#(
    parameter int       DATA_W  = 16,
    parameter int       GUARD_W = 2,
    parameter tap_set_e TAP_SET = TAPS_SMOOTH
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_sample,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_sample
);
    localparam int ACC_W = DATA_W + GUARD_W;
    localparam logic [ACC_W-1:0] ONE = {{(ACC_W-1){1'b0}}, 1'b1};

    // independent reference built from the formula
    logic [DATA_W-1:0]       h1, h2;
    logic signed [ACC_W-1:0] wx, w1, w2, mid, ref_next;
    logic [DATA_W-1:0]       ref_q;

    assign wx  = {{GUARD_W{in_sample[DATA_W-1]}}, in_sample};
    assign w1  = {{GUARD_W{h1[DATA_W-1]}}, h1};
    assign w2  = {{GUARD_W{h2[DATA_W-1]}}, h2};
    assign mid = w1 >>> 1;
    assign ref_next = (wx >>> 2) + ((TAP_SET == TAPS_EDGE) ? ((~mid) + ONE) : mid)
                    + (w2 >>> 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            h1 <= '0; h2 <= '0; ref_q <= '0;
        end else if (in_valid) begin
            h1 <= in_sample; h2 <= h1; ref_q <= ref_next[DATA_W-1:0];
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_sample == '0));

    // R4
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R4
    valid_source_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R5
    gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_sample));

    // R2 R3
    result_match_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sample == ref_q));
endmodule

bind shfir_top shfir_checker #(
    .DATA_W(DATA_W), .GUARD_W(GUARD_W), .TAP_SET(TAP_SET)
) u_shfir_checker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample)
);

// File: tb/shfir_top_bench.sv
`timescale 1ns/1ps
module shfir_top_bench;
    import shfir_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;

    logic        v_lpd, v_lpr, v_hpd, v_hpr;
    logic [15:0] y_lpd, y_lpr, y_hpd, y_hpr;

    int total = 0;
    int bad = 0;
    int h1 = 0, h2 = 0;   // bench history of accepted samples

    always #10 clk = ~clk;   // 50 MHz

    shfir_top u_shfir_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(v_lpd), .out_sample(y_lpd));
    shfir_top #(.TAP_SET(TAPS_SMOOTH), .FORM(FORM_RETIMED)) u_lp_ret (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(v_lpr), .out_sample(y_lpr));
    shfir_top #(.TAP_SET(TAPS_EDGE), .FORM(FORM_DIRECT)) u_hp_dir (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(v_hpd), .out_sample(y_hpd));
    shfir_top #(.TAP_SET(TAPS_EDGE), .FORM(FORM_RETIMED)) u_hp_ret (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(v_hpr), .out_sample(y_hpr));

    // stimulus sample and expected low-pass output, history zero at start
    localparam int N_VEC = 8;
    localparam int VEC [N_VEC][2] = '{
        '{4, 1}, '{8, 4}, '{-4, 4}, '{100, 25},
        '{-32768, -8143}, '{32767, -8168}, '{32767, 16382}, '{-1, 24573}
    };

    function automatic logic [15:0] model(int x, int x1, int x2, bit neg);
        int m;
        m = x1 >>> 1;
        return 16'((x >>> 2) + (neg ? -m : m) + (x2 >>> 2));
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req,
                     $signed(act), $signed(exp));
        end
    endtask

    // apply one cycle at a falling edge, then sample at the next falling edge
    task automatic step(bit v, int x);
        in_valid  = v;
        in_sample = 16'(x);
        @(posedge clk);
        @(negedge clk);
        if (v) begin
            h2 = h1;
            h1 = x;
        end
    endtask

    // expected values computed before the history moves
    task automatic push_check(int x, string req);
        logic [15:0] e_lp, e_hp;
        e_lp = model(x, h1, h2, 1'b0);
        e_hp = model(x, h1, h2, 1'b1);
        step(1'b1, x);
        check({req, " R4 valid"}, {15'd0, v_lpd}, 16'd1);
        check({req, " R2 smooth"}, y_lpd, e_lp);
        check({req, " R3 edge"}, y_hpd, e_hp);
        check({req, " R6 smooth retimed"}, y_lpr, y_lpd);
        check({req, " R6 edge retimed"}, y_hpr, y_hpd);
        check({req, " R6 valid"}, {14'd0, v_lpr, v_hpr}, {14'd0, v_lpd, v_hpd});
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset with valid stimulus present is ignored
        @(negedge clk);
        in_valid = 1'b1; in_sample = 16'd1000;
        repeat (3) @(negedge clk);
        check("R1 out_valid", {15'd0, v_lpd}, 16'd0);
        check("R1 smooth sample", y_lpd, 16'd0);
        check("R1 edge sample", y_hpr, 16'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        // R2 R8: table walk
        for (int i = 0; i < N_VEC; i++) begin
            logic [15:0] e_hp;
            e_hp = model(VEC[i][0], h1, h2, 1'b1);
            step(1'b1, VEC[i][0]);
            check("R2 R8 table smooth", y_lpd, 16'(VEC[i][1]));
            check("R6 table smooth retimed", y_lpr, 16'(VEC[i][1]));
            check("R3 table edge", y_hpd, e_hp);
            check("R6 table edge retimed", y_hpr, e_hp);
            check("R4 table valid", {15'd0, v_lpd}, 16'd1);
        end

        // R5: gap with junk data changes nothing
        step(1'b0, 12345);
        check("R4 gap valid low", {15'd0, v_lpd}, 16'd0);
        check("R5 gap hold smooth", y_lpd, 16'd24573);
        step(1'b0, -999);
        check("R5 gap hold retimed", y_lpr, 16'd24573);
        // next sample uses history -1, 32767: 0 + (-1) + 8191
        push_check(0, "R5 after gap");
        check("R5 after gap value", y_lpd, 16'd8190);

        // R7: full scale
        push_check(32767, "R7 fs");
        push_check(32767, "R7 fs");
        push_check(32767, "R7 fs");
        check("R7 smooth full scale", y_lpd, 16'd32765);
        push_check(-32768, "R7 alt");
        push_check(32767, "R7 alt");
        push_check(-32768, "R7 alt");
        check("R7 edge full scale", y_hpd, 16'(-32767));

        // R8: small negatives, history -1 then -1
        push_check(-1, "R8 neg");
        push_check(-1, "R8 neg");
        push_check(-1, "R8 neg");
        check("R8 arithmetic shift", y_lpd, 16'(-3));

        // R1: reset in mid-stream clears history
        push_check(500, "pre reset");
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid reset out_valid", {15'd0, v_hpr}, 16'd0);
        check("R1 mid reset sample", y_lpr, 16'd0);
        h1 = 0; h2 = 0;
        push_check(8, "R1 after reset");
        check("R1 fresh history", y_lpd, 16'd2);
        step(1'b0, 0);
        finish_run();
    end
endmodule